// File: doc/BRIEF.md
# Network Loopback Code Detector

This block watches a recovered serial data stream, one bit per receive clock when a bit-valid strobe is high, and looks for two in-band control codes. A repeating code with a period of five bits that carries a single one (zeros then a one) requests network loopback. A repeating code with a period of three bits that carries a single one requests release. Each code must be seen without a break for a set number of one-second tick pulses before it has any effect. When the activate code qualifies, a network-loopback flag is set and the data path is placed in remote loopback. When the release code qualifies, the flag is cleared.

Three static control inputs are decoded into an operating mode. These inputs are remote-loop, local-loop and send-all-ones. Depending on the combination, the decode selects local loopback, loopback at the jitter-attenuator point with an all-ones transmit, remote loopback, or a chip reset. Only when all three inputs are high is code detection armed. Code detection runs only while it is armed. An active-low interrupt tells the host when the loopback flag, an external loss-of-signal flag or an external alarm-indication flag changes. The interrupt stays asserted until the host clears it.

Top module: `nloop_code_detector`

## Requirements
- R1: After synchronous reset, `nloop` is 0 and `irq_n` is 1.
- R2: With inputs {rmt_loop, loc_loop, send_ones} = 3'b111, only `det_armed` is high among the mode outputs. With 3'b110, only `chip_rst` is high.
- R3: With 3'b000, all mode outputs are low. With 3'b001, only `tx_all_ones` is high. With 3'b010, only `lb_local` is high. With 3'b011, only `lb_ja_point` and `tx_all_ones` are high.
- R4: With rmt_loop=1 and loc_loop=0, `lb_remote` is high whatever the value of send_ones. No other mode output is high in this case.
- R5: While detection is armed, the activate code (period 5, bit value 1 only in the last position) must be received without a break across QUAL_SECS tick pulses. `nloop` is then set. It is still 0 after QUAL_SECS-1 ticks.
- R6: While detection is not armed, neither code has any effect. In modes 3'b000 and 3'b001, `nloop` keeps its value.
- R7: While detection is armed and `nloop` is 1, the release code (period 3, bit value 1 only in the last position) must be received without a break across QUAL_SECS ticks. `nloop` then returns to 0. It is still 1 after QUAL_SECS-1 ticks.
- R8: `lb_remote` is high whenever `nloop` is 1.
- R9: In local, jitter-attenuator-point, remote or chip-reset mode, `nloop` is cleared at the next clock edge.
- R10: A change in `nloop`, `los_in` or `ais_in` drives `irq_n` low within two clocks.
- R11: `irq_n` stays low until an `irq_clr` strobe. A new change that arrives in the same cycle as the clear keeps it low.
- R12: A code is recognised at any bit phase. A one that arrives after the wrong number of zeros, or a run of zeros that is too long, restarts that code's tick count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Recovered bit valid |
| rx_bit | input | 1 | Recovered data bit |
| sec_tick | input | 1 | One-cycle pulse once per second |
| rmt_loop | input | 1 | Remote-loop control input |
| loc_loop | input | 1 | Local-loop control input |
| send_ones | input | 1 | All-ones transmit control input |
| los_in | input | 1 | Loss-of-signal status |
| ais_in | input | 1 | Alarm-indication status |
| irq_clr | input | 1 | Host interrupt clear strobe |
| lb_local | output | 1 | Full local loopback selected |
| lb_ja_point | output | 1 | Loopback at the jitter-attenuator point |
| lb_remote | output | 1 | Remote loopback (by control input or by code) |
| tx_all_ones | output | 1 | Transmitter sends continuous ones |
| chip_rst | output | 1 | Chip reset request |
| det_armed | output | 1 | Code detection armed |
| nloop | output | 1 | Network loopback flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench counts ticks at the qualification boundary. If a timer counts one tick short or one tick long, the flag is seen to move at the fourth tick or fails to move at the fifth. It breaks an activate run with a single extra zero. A design that only pauses its timer on a mismatch, instead of restarting it, would then set the flag too early. It also checks that the flag holds in the unarmed modes but drops at once in the loopback and reset modes. Finally, it lands a status change on the same cycle as a host clear. A clear that wins that race would lose the event.

// File: rtl/nlcd_pkg.sv
package nlcd_pkg;

    typedef struct packed {
        logic local_lb;
        logic ja_lb;
        logic remote_lb;
        logic send_ones;
        logic chip_rst;
        logic armed;
    } mode_ctl_t;

    function automatic mode_ctl_t decode_mode(input logic rmt, input logic loc, input logic aos);
        mode_ctl_t m;
        m = '0;
        case ({rmt, loc, aos})
            3'b001:  m.send_ones = 1'b1;
            3'b010:  m.local_lb  = 1'b1;
            3'b011: begin
                m.ja_lb     = 1'b1;
                m.send_ones = 1'b1;
            end
            3'b100,
            3'b101:  m.remote_lb = 1'b1;
            3'b110:  m.chip_rst  = 1'b1;
            3'b111:  m.armed     = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic forces_release(input mode_ctl_t m);
        return m.local_lb | m.ja_lb | m.remote_lb | m.chip_rst;
    endfunction

endpackage

// File: rtl/nlcd_pattern_match.sv
module nlcd_pattern_match #(
    parameter int PERIOD = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bit_vld,
    input  logic bit_in,
    output logic in_sync
);
    localparam int ZW = $clog2(PERIOD + 1);
    localparam logic [ZW-1:0] GAP = ZW'(PERIOD - 1);
    localparam logic [ZW-1:0] ZMAX = ZW'(PERIOD);

    logic [ZW-1:0] zrun_q;
    logic          sync_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            zrun_q <= '0;
            sync_q <= 1'b0;
        end else if (bit_vld) begin
            if (bit_in) begin
                sync_q <= (zrun_q == GAP);
                zrun_q <= '0;
            end else begin
                if (zrun_q >= GAP)
                    sync_q <= 1'b0;
                if (zrun_q < ZMAX)
                    zrun_q <= zrun_q + 1'b1;
            end
        end
    end

    assign in_sync = sync_q;

    // R12
    zero_run_bound_chk: assert property (@(posedge clk) disable iff (rst) zrun_q <= ZMAX);

    // R12
    sync_on_one_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_q) |-> $past(bit_vld && bit_in && en));

endmodule

// File: rtl/nlcd_qual_timer.sv
module nlcd_qual_timer #(
    parameter int SECS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic qualified
);
    localparam int CW = $clog2(SECS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SECS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (tick && cnt_q < LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign qualified = (cnt_q == LIMIT);

    // R5
    timer_limit_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= LIMIT);

    // R12
    timer_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/nlcd_irq.sv
module nlcd_irq (
    input  logic clk,
    input  logic rst,
    input  logic flag_a,
    input  logic flag_b,
    input  logic flag_c,
    input  logic clr,
    output logic pend
);
    logic [2:0] prev_q;
    logic       pend_q;
    logic       change;

    assign change = (prev_q != {flag_a, flag_b, flag_c});

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= {flag_a, flag_b, flag_c};
            if (change)
                pend_q <= 1'b1;
            else if (clr)
                pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;

    // R10
    irq_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        change |=> pend_q);

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr) |=> pend_q);

endmodule

// File: rtl/nloop_code_detector.sv
module nloop_code_detector
    import nlcd_pkg::*;
#(
    parameter int ACT_PERIOD   = 5,
    parameter int REL_PERIOD   = 3,
    parameter int QUAL_SECS    = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_vld,
    input  logic rx_bit,
    input  logic sec_tick,
    input  logic rmt_loop,
    input  logic loc_loop,
    input  logic send_ones,
    input  logic los_in,
    input  logic ais_in,
    input  logic irq_clr,
    output logic lb_local,
    output logic lb_ja_point,
    output logic lb_remote,
    output logic tx_all_ones,
    output logic chip_rst,
    output logic det_armed,
    output logic nloop,
    output logic irq_n
);
    localparam int NCODES = 2;

    mode_ctl_t mode;
    logic      release_mode;
    logic      nloop_q;
    logic      irq_pend;
    logic [NCODES-1:0] code_sync;
    logic [NCODES-1:0] code_qual;

    assign mode         = decode_mode(rmt_loop, loc_loop, send_ones);
    assign release_mode = forces_release(mode);

    genvar g;
    generate
        for (g = 0; g < NCODES; g++) begin : g_code
            localparam int P = (g == 0) ? ACT_PERIOD : REL_PERIOD;
            nlcd_pattern_match #(.PERIOD(P)) u_match (
                .clk     (clk),
                .rst     (rst),
                .en      (mode.armed),
                .bit_vld (rx_vld),
                .bit_in  (rx_bit),
                .in_sync (code_sync[g])
            );
            nlcd_qual_timer #(.SECS(QUAL_SECS)) u_timer (
                .clk       (clk),
                .rst       (rst),
                .run       (mode.armed && code_sync[g]),
                .tick      (sec_tick),
                .qualified (code_qual[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || release_mode)
            nloop_q <= 1'b0;
        else if (mode.armed) begin
            if (!nloop_q && code_qual[0])
                nloop_q <= 1'b1;
            else if (nloop_q && code_qual[1])
                nloop_q <= 1'b0;
        end
    end

    nlcd_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .flag_a (nloop_q),
        .flag_b (los_in),
        .flag_c (ais_in),
        .clr    (irq_clr),
        .pend   (irq_pend)
    );

    assign lb_local    = mode.local_lb;
    assign lb_ja_point = mode.ja_lb;
    assign lb_remote   = mode.remote_lb | nloop_q;
    assign tx_all_ones = mode.send_ones;
    assign chip_rst    = mode.chip_rst;
    assign det_armed   = mode.armed;
    assign nloop       = nloop_q;
    assign irq_n       = ~irq_pend;

    // R2
    mode_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mode.local_lb, mode.ja_lb, mode.remote_lb, mode.chip_rst, mode.armed}));

    // R5
    set_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nloop_q) |-> $past(mode.armed));

    // R9
    release_clears_chk: assert property (@(posedge clk) disable iff (rst)
        release_mode |=> !nloop_q);

    // R8
    remote_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
        nloop_q |-> lb_remote);

endmodule

// File: tb/nloop_code_detector_test.sv
module nloop_code_detector_test;
    logic clk = 1'b0;
    logic rst, rx_vld, rx_bit, sec_tick, rmt_loop, loc_loop, send_ones;
    logic los_in, ais_in, irq_clr;
    logic lb_local, lb_ja_point, lb_remote, tx_all_ones, chip_rst, det_armed, nloop, irq_n;

    int checks = 0;
    int fails = 0;
    int ph = 0;

    always #2.5 clk = ~clk;

    nloop_code_detector uut (
        .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_bit(rx_bit), .sec_tick(sec_tick),
        .rmt_loop(rmt_loop), .loc_loop(loc_loop), .send_ones(send_ones),
        .los_in(los_in), .ais_in(ais_in), .irq_clr(irq_clr),
        .lb_local(lb_local), .lb_ja_point(lb_ja_point), .lb_remote(lb_remote),
        .tx_all_ones(tx_all_ones), .chip_rst(chip_rst), .det_armed(det_armed),
        .nloop(nloop), .irq_n(irq_n)
    );

    // {rmt,loc,ones} -> {local,ja,remote,all_ones,chip_rst,armed}
    localparam logic [8:0] MODE_VEC [8] = '{
        {3'b000, 6'b000000}, {3'b001, 6'b000100}, {3'b010, 6'b100000}, {3'b011, 6'b010100},
        {3'b100, 6'b001000}, {3'b101, 6'b001000}, {3'b110, 6'b000010}, {3'b111, 6'b000001}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic t);
        @(negedge clk);
        rx_vld = 1'b1;
        rx_bit = b;
        sec_tick = t;
    endtask

    task automatic next_code_bit(input int period, input logic t);
        send_bit(ph == period - 1, t);
        ph = (ph + 1) % period;
    endtask

    task automatic run_code(input int period, input int nticks, input bit prime);
        if (prime)
            for (int i = 0; i < 2 * period; i++) next_code_bit(period, 1'b0);
        for (int t = 0; t < nticks; t++) begin
            for (int k = 0; k < 20; k++) next_code_bit(period, 1'b0);
            next_code_bit(period, 1'b1);
        end
        for (int k = 0; k < 4; k++) next_code_bit(period, 1'b0);
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        {rmt_loop, loc_loop, send_ones} = m;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_vld = 1'b0; rx_bit = 1'b0; sec_tick = 1'b0;
        rmt_loop = 1'b0; loc_loop = 1'b0; send_ones = 1'b0;
        los_in = 1'b0; ais_in = 1'b0; irq_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 nloop after reset", {7'd0, nloop}, 8'd0);
        chk("R1 irq_n after reset", {7'd0, irq_n}, 8'd1);

        // R2 R3 R4: mode decode table
        for (int i = 0; i < 8; i++) begin
            set_mode(MODE_VEC[i][8:6]);
            @(negedge clk);
            chk("R2/R3/R4 mode decode",
                {2'b00, lb_local, lb_ja_point, lb_remote, tx_all_ones, chip_rst, det_armed},
                {2'b00, MODE_VEC[i][5:0]});
        end

        // R6: unarmed, activate code has no effect
        set_mode(3'b000);
        ph = 0;
        run_code(5, 7, 1'b1);
        chk("R6 no set while unarmed", {7'd0, nloop}, 8'd0);

        // R5: armed activation boundary
        set_mode(3'b111);
        ph = 0;
        run_code(5, 4, 1'b1);
        chk("R5 not set after 4 ticks", {7'd0, nloop}, 8'd0);
        run_code(5, 1, 1'b0);
        chk("R5 set after 5 ticks", {7'd0, nloop}, 8'd1);
        chk("R8 remote loop follows flag", {7'd0, lb_remote}, 8'd1);
        chk("R10 irq on flag set", {7'd0, irq_n}, 8'd0);
        pulse_clr();
        @(negedge clk);
        chk("R11 irq cleared", {7'd0, irq_n}, 8'd1);

        // R6: flag holds in unarmed idle mode
        set_mode(3'b000);
        ph = 0;
        run_code(3, 6, 1'b1);
        chk("R6 flag holds unarmed", {7'd0, nloop}, 8'd1);
        chk("R8 remote while flag held", {7'd0, lb_remote}, 8'd1);

        // R7: release boundary
        set_mode(3'b111);
        ph = 0;
        run_code(3, 4, 1'b1);
        chk("R7 still set after 4 ticks", {7'd0, nloop}, 8'd1);
        run_code(3, 1, 1'b0);
        chk("R7 cleared after 5 ticks", {7'd0, nloop}, 8'd0);
        pulse_clr();

        // R12: mismatch restarts the timer, phase is arbitrary
        ph = 2;
        run_code(5, 3, 1'b1);
        send_bit(1'b0, 1'b0);
        run_code(5, 4, 1'b0);
        chk("R12 restart after glitch", {7'd0, nloop}, 8'd0);
        run_code(5, 1, 1'b0);
        chk("R12 set after full run", {7'd0, nloop}, 8'd1);

        // R9: local loop clears at once
        set_mode(3'b010);
        @(negedge clk);
        chk("R9 local mode clears", {7'd0, nloop}, 8'd0);

        set_mode(3'b111);
        ph = 0;
        run_code(5, 5, 1'b1);
        chk("R5 set again", {7'd0, nloop}, 8'd1);
        set_mode(3'b110);
        @(negedge clk);
        chk("R9 reset mode clears", {7'd0, nloop}, 8'd0);

        set_mode(3'b111);
        ph = 0;
        run_code(5, 5, 1'b1);
        set_mode(3'b101);
        @(negedge clk);
        chk("R9 remote mode clears", {7'd0, nloop}, 8'd0);
        chk("R4 remote still selected", {7'd0, lb_remote}, 8'd1);

        // R10 R11: status inputs
        set_mode(3'b000);
        repeat (3) @(negedge clk);
        pulse_clr();
        @(negedge clk);
        chk("R11 cleared before status", {7'd0, irq_n}, 8'd1);
        los_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 irq on los", {7'd0, irq_n}, 8'd0);
        pulse_clr();
        @(negedge clk);
        ais_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 irq on ais", {7'd0, irq_n}, 8'd0);
        pulse_clr();
        @(negedge clk);
        chk("R11 clear works", {7'd0, irq_n}, 8'd1);
        ais_in = 1'b0;
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        @(negedge clk);
        chk("R11 change beats clear", {7'd0, irq_n}, 8'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule